// File: doc/BRIEF.md
# Radio Frame Timer with Programmable Events

This block is the timing heart of a baseband radio front end and runs on the dual-byte clock. It keeps three radio timers, each made of a clock count, a symbol count and a frame count: one main timer, one for the uplink and one for the downlink. The uplink and downlink timers are the main timer delayed or advanced by a fixed number of byte clocks. That shift is set by the value each timer loads on a sync pulse. Symbols need not all have the same length. A 16-entry table of clock terminal counts is walked one entry per symbol, so the symbol boundaries can follow the irregular layout of a frame. A separate physical-layer timer counts only clocks and frames. For a 10 ms frame its terminal count is programmed to 3071999 with a 307.2 MHz byte clock, or to 2457599 with a 245.76 MHz byte clock.

Eight event generators produce one-cycle strobes. Each one takes one of the six symbol or frame boundaries of the three radio timers as its reference. The first strobe comes a programmable number of clocks after that reference. The later strobes repeat at a programmable period until the next reference restarts the sequence. A sync pulse reloads every counter and puts every event generator back into waiting for its reference.

Top module: `radio_frame_timer`

## Requirements
- R1: After reset every clock, symbol and frame count of the three radio timers and of the physical-layer timer reads 0, and no event strobe is high.
- R2: A radio timer's clock count rises by one each cycle. Its symbol strobe is high in the cycle where the clock count equals the table entry selected by its current table index, and in the next cycle the clock count is 0 and the symbol count has risen by one.
- R3: The table index advances by one at each symbol end and wraps from 15 to 0, so symbol k of a frame lasts entry (k mod 16) plus one clocks. Entry i sits at bits [22*i+21 : 22*i] of the table input.
- R4: The frame strobe is high at a symbol end where the symbol count equals the symbol terminal count. The next cycle the symbol count and table index are 0, and the frame count has risen by one or, if it equalled the frame terminal count, wrapped to 0.
- R5: One cycle after sync the main clock count is 0, the uplink and downlink clock counts hold their init values, and all symbol and frame counts are 0. Timer slices are ordered main (0), uplink (1), downlink (2) in the packed outputs.
- R6: The physical-layer timer counts clocks from 0 to its terminal count. Its strobe is high in the terminal cycle, after which the clock count returns to 0 and its frame count rises by one.
- R7: Event reference codes are 0 main symbol, 1 main frame, 2 uplink symbol, 3 uplink frame, 4 downlink symbol, 5 downlink frame, and 6 or 7 none. The first event strobe comes offset+1 cycles after the reference strobe cycle.
- R8: After a strobe an event repeats every modulo cycles, and a new reference strobe restarts the offset phase.
- R9: An event whose modulo is 0 shows no strobe from the next cycle on.
- R10: One cycle after sync no event strobe is high, and none is high until that event's reference strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dual-byte clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Reload all counters and re-arm events |
| lut_tc_i | input | 16*22 | Per-symbol clock terminal counts, entry i at bits 22*i upward |
| sym_tc_i | input | 8 | Last symbol number of a frame |
| frm_tc_i | input | 12 | Last frame number before wrap |
| ul_init_i | input | 22 | Uplink clock count loaded on sync |
| dl_init_i | input | 22 | Downlink clock count loaded on sync |
| phy_tc_i | input | 22 | Physical-layer clock terminal count |
| evt_sel_i | input | 8*3 | Reference code per event |
| evt_mod_i | input | 8*22 | Period per event, 0 disables |
| evt_off_i | input | 8*22 | Delay to the first strobe per event |
| tmr_clk_o | output | 3*22 | Clock counts: main, uplink, downlink |
| tmr_sym_o | output | 3*8 | Symbol counts |
| tmr_frm_o | output | 3*12 | Frame counts |
| sym_stb_o | output | 3 | Symbol boundary strobes |
| frm_stb_o | output | 3 | Frame boundary strobes |
| phy_clk_o | output | 22 | Physical-layer clock count |
| phy_frm_o | output | 12 | Physical-layer frame count |
| phy_stb_o | output | 1 | Physical-layer frame strobe |
| evt_o | output | 8 | Event strobes |

## Verification
A wrong table index or symbol count in a radio timer shows at the count outputs on the very next symbol boundary, because the strobe lands on the wrong clock count. It also shifts every event referenced to that timer by the same amount. A bad event down-counter appears as a strobe that is early, late or missing within one modulo period of the reference. Comparing every count, strobe and event output with an independent model each cycle catches such faults within the symbol where they arise.

// File: rtl/rft_pkg.sv
package rft_pkg;
    localparam int CLK_W     = 22;
    localparam int SYM_W     = 8;
    localparam int FRM_W     = 12;
    localparam int LUT_DEPTH = 16;
    localparam int N_EVT     = 8;
    localparam int EVT_W     = 22;
    localparam int N_TMR     = 3;
    localparam int N_REF     = 2 * N_TMR;
    localparam int SEL_W     = 3;

    typedef enum logic [SEL_W-1:0] {
        REF_MAIN_SYM = 3'd0,
        REF_MAIN_FRM = 3'd1,
        REF_UL_SYM   = 3'd2,
        REF_UL_FRM   = 3'd3,
        REF_DL_SYM   = 3'd4,
        REF_DL_FRM   = 3'd5,
        REF_OFF_A    = 3'd6,
        REF_OFF_B    = 3'd7
    } ref_sel_e;

    // Returns the boundary strobe named by a reference code; codes past the
    // last boundary select nothing.
    function automatic logic pick_ref(input logic [SEL_W-1:0] sel,
                                      input logic [N_REF-1:0] refs);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            if (sel == SEL_W'(i)) hit = refs[i];
        end
        return hit;
    endfunction
endpackage

// File: rtl/rft_radio_ctr.sv
module rft_radio_ctr #(
    parameter int CLK_W = 22,
    parameter int SYM_W = 8,
    parameter int FRM_W = 12,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sync_i,
    input  logic [CLK_W-1:0]       init_clk_i,
    input  logic [DEPTH*CLK_W-1:0] lut_i,
    input  logic [SYM_W-1:0]       sym_tc_i,
    input  logic [FRM_W-1:0]       frm_tc_i,
    output logic [CLK_W-1:0]       clk_o,
    output logic [SYM_W-1:0]       sym_o,
    output logic [FRM_W-1:0]       frm_o,
    output logic                   sym_stb_o,
    output logic                   frm_stb_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [CLK_W-1:0] clk;
        logic [SYM_W-1:0] sym;
        logic [FRM_W-1:0] frm;
        logic [IDX_W-1:0] idx;
    } ctr_t;

    logic [CLK_W-1:0] tc_tab [DEPTH];
    ctr_t q, d;
    logic sym_end, frm_end;

    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
        assign tc_tab[g] = lut_i[g*CLK_W +: CLK_W];
    end

    always_comb begin
        sym_end = (q.clk == tc_tab[q.idx]);
        frm_end = sym_end && (q.sym == sym_tc_i);
        d = q;
        if (sync_i) begin
            d     = '0;
            d.clk = init_clk_i;
        end else if (!sym_end) begin
            d.clk = q.clk + 1'b1;
        end else begin
            d.clk = '0;
            if (frm_end) begin
                d.sym = '0;
                d.idx = '0;
                d.frm = (q.frm == frm_tc_i) ? '0 : q.frm + 1'b1;
            end else begin
                d.sym = q.sym + 1'b1;
                d.idx = (q.idx == IDX_LAST) ? '0 : q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign clk_o     = q.clk;
    assign sym_o     = q.sym;
    assign frm_o     = q.frm;
    assign sym_stb_o = sym_end;
    assign frm_stb_o = frm_end;
endmodule

// File: rtl/rft_phy_ctr.sv
module rft_phy_ctr #(
    parameter int CLK_W = 22,
    parameter int FRM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic [CLK_W-1:0] tc_i,
    output logic [CLK_W-1:0] clk_o,
    output logic [FRM_W-1:0] frm_o,
    output logic             stb_o
);
    logic [CLK_W-1:0] clk_q;
    logic [FRM_W-1:0] frm_q;
    logic             wrap;

    assign wrap = (clk_q == tc_i);

    always_ff @(posedge clk) begin
        if (rst || sync_i) begin
            clk_q <= '0;
            frm_q <= '0;
        end else if (wrap) begin
            clk_q <= '0;
            frm_q <= frm_q + 1'b1;
        end else begin
            clk_q <= clk_q + 1'b1;
        end
    end

    assign clk_o = clk_q;
    assign frm_o = frm_q;
    assign stb_o = wrap;
endmodule

// File: rtl/rft_event_gen.sv
module rft_event_gen
    import rft_pkg::*;
#(
    parameter int EVT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic [N_REF-1:0] refs_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [EVT_W-1:0] mod_i,
    input  logic [EVT_W-1:0] off_i,
    output logic             evt_o
);
    typedef struct packed {
        logic             active;
        logic [EVT_W-1:0] cnt;
    } evt_state_t;

    evt_state_t st;
    logic       ref_hit;

    assign ref_hit = pick_ref(sel_i, refs_i);

    always_ff @(posedge clk) begin
        if (rst || sync_i) begin
            st <= '0;
        end else if (mod_i == '0) begin
            st.active <= 1'b0;
        end else if (ref_hit) begin
            st.active <= 1'b1;
            st.cnt    <= off_i;
        end else if (st.active) begin
            st.cnt <= (st.cnt == '0) ? mod_i - 1'b1 : st.cnt - 1'b1;
        end
    end

    assign evt_o = st.active && (st.cnt == '0);
endmodule

// File: rtl/radio_frame_timer.sv
module radio_frame_timer
    import rft_pkg::*;
#(
    parameter int CLK_W = rft_pkg::CLK_W,
    parameter int SYM_W = rft_pkg::SYM_W,
    parameter int FRM_W = rft_pkg::FRM_W,
    parameter int DEPTH = rft_pkg::LUT_DEPTH,
    parameter int NEVT  = rft_pkg::N_EVT,
    parameter int EVT_W = rft_pkg::EVT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sync_i,
    input  logic [DEPTH*CLK_W-1:0] lut_tc_i,
    input  logic [SYM_W-1:0]       sym_tc_i,
    input  logic [FRM_W-1:0]       frm_tc_i,
    input  logic [CLK_W-1:0]       ul_init_i,
    input  logic [CLK_W-1:0]       dl_init_i,
    input  logic [CLK_W-1:0]       phy_tc_i,
    input  logic [NEVT*SEL_W-1:0]  evt_sel_i,
    input  logic [NEVT*EVT_W-1:0]  evt_mod_i,
    input  logic [NEVT*EVT_W-1:0]  evt_off_i,
    output logic [N_TMR*CLK_W-1:0] tmr_clk_o,
    output logic [N_TMR*SYM_W-1:0] tmr_sym_o,
    output logic [N_TMR*FRM_W-1:0] tmr_frm_o,
    output logic [N_TMR-1:0]       sym_stb_o,
    output logic [N_TMR-1:0]       frm_stb_o,
    output logic [CLK_W-1:0]       phy_clk_o,
    output logic [FRM_W-1:0]       phy_frm_o,
    output logic                   phy_stb_o,
    output logic [NEVT-1:0]        evt_o
);
    logic [CLK_W-1:0] init_v [N_TMR];
    logic [N_REF-1:0] refs;

    assign init_v[0] = '0;
    assign init_v[1] = ul_init_i;
    assign init_v[2] = dl_init_i;

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        rft_radio_ctr #(
            .CLK_W(CLK_W), .SYM_W(SYM_W), .FRM_W(FRM_W), .DEPTH(DEPTH)
        ) u_ctr (
            .clk        (clk),
            .rst        (rst),
            .sync_i     (sync_i),
            .init_clk_i (init_v[t]),
            .lut_i      (lut_tc_i),
            .sym_tc_i   (sym_tc_i),
            .frm_tc_i   (frm_tc_i),
            .clk_o      (tmr_clk_o[t*CLK_W +: CLK_W]),
            .sym_o      (tmr_sym_o[t*SYM_W +: SYM_W]),
            .frm_o      (tmr_frm_o[t*FRM_W +: FRM_W]),
            .sym_stb_o  (sym_stb_o[t]),
            .frm_stb_o  (frm_stb_o[t])
        );
        assign refs[2*t]   = sym_stb_o[t];
        assign refs[2*t+1] = frm_stb_o[t];
    end

    rft_phy_ctr #(.CLK_W(CLK_W), .FRM_W(FRM_W)) u_phy (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_i),
        .tc_i   (phy_tc_i),
        .clk_o  (phy_clk_o),
        .frm_o  (phy_frm_o),
        .stb_o  (phy_stb_o)
    );

    for (genvar e = 0; e < NEVT; e++) begin : g_evt
        rft_event_gen #(.EVT_W(EVT_W)) u_evt (
            .clk    (clk),
            .rst    (rst),
            .sync_i (sync_i),
            .refs_i (refs),
            .sel_i  (evt_sel_i[e*SEL_W +: SEL_W]),
            .mod_i  (evt_mod_i[e*EVT_W +: EVT_W]),
            .off_i  (evt_off_i[e*EVT_W +: EVT_W]),
            .evt_o  (evt_o[e])
        );
    end
endmodule

// File: rtl/rft_checker.sv
module rft_checker
    import rft_pkg::*;
#(
    parameter int CLK_W = 22,
    parameter int SYM_W = 8,
    parameter int NEVT  = 8,
    parameter int EVT_W = 22
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sync_i,
    input logic [CLK_W-1:0]       ul_init_i,
    input logic [CLK_W-1:0]       dl_init_i,
    input logic [NEVT*EVT_W-1:0]  evt_mod_i,
    input logic [N_TMR*CLK_W-1:0] tmr_clk_o,
    input logic [N_TMR*SYM_W-1:0] tmr_sym_o,
    input logic [N_TMR-1:0]       sym_stb_o,
    input logic [N_TMR-1:0]       frm_stb_o,
    input logic [CLK_W-1:0]       phy_clk_o,
    input logic                   phy_stb_o,
    input logic [NEVT-1:0]        evt_o
);
    p_clk_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!sync_i && !sym_stb_o[0]) |=>
            tmr_clk_o[CLK_W-1:0] == $past(tmr_clk_o[CLK_W-1:0]) + 1'b1);

    p_sym_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (!sync_i && sym_stb_o[0]) |=> tmr_clk_o[CLK_W-1:0] == '0);

    p_frame_sym_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (!sync_i && frm_stb_o[0]) |=> tmr_sym_o[SYM_W-1:0] == '0);

    p_sync_load_r5: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (tmr_clk_o[CLK_W-1:0] == '0)
                && (tmr_clk_o[CLK_W +: CLK_W] == $past(ul_init_i))
                && (tmr_clk_o[2*CLK_W +: CLK_W] == $past(dl_init_i)));

    p_phy_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!sync_i && phy_stb_o) |=> phy_clk_o == '0);

    p_sync_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> evt_o == '0);

    for (genvar e = 0; e < NEVT; e++) begin : g_evt_chk
        p_mod_zero_off_r9: assert property (@(posedge clk) disable iff (rst)
            (evt_mod_i[e*EVT_W +: EVT_W] == '0) |=> !evt_o[e]);
    end
endmodule

bind radio_frame_timer rft_checker #(
    .CLK_W(CLK_W), .SYM_W(SYM_W), .NEVT(NEVT), .EVT_W(EVT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_i    (sync_i),
    .ul_init_i (ul_init_i),
    .dl_init_i (dl_init_i),
    .evt_mod_i (evt_mod_i),
    .tmr_clk_o (tmr_clk_o),
    .tmr_sym_o (tmr_sym_o),
    .sym_stb_o (sym_stb_o),
    .frm_stb_o (frm_stb_o),
    .phy_clk_o (phy_clk_o),
    .phy_stb_o (phy_stb_o),
    .evt_o     (evt_o)
);

// File: tb/sim_radio_frame_timer.sv
`timescale 1ns/100ps
module sim_radio_frame_timer;
    localparam int CW = 22, SW = 8, FW = 12, DEP = 16, NE = 8, EW = 22;

    typedef struct packed {
        int lutb; int stc; int ftc; int ul; int dl;
        int ptc;  int modb; int offb; int rot;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{3, 3, 2, 1, 3, 9, 5, 1, 0},
        '{1, 20, 1, 0, 1, 4, 2, 0, 3},
        '{6, 0, 3, 4, 2, 30, 0, 2, 5},
        '{2, 5, 0, 2, 0, 1, 11, 3, 1}
    };

    logic clk = 1'b0, rst = 1'b1, sync = 1'b0;
    logic [DEP*CW-1:0] lut;
    logic [SW-1:0] sym_tc;
    logic [FW-1:0] frm_tc;
    logic [CW-1:0] ul_init, dl_init, phy_tc;
    logic [NE*3-1:0] esel;
    logic [NE*EW-1:0] emod, eoff;
    logic [3*CW-1:0] tclk;
    logic [3*SW-1:0] tsym;
    logic [3*FW-1:0] tfrm;
    logic [2:0] sstb, fstb;
    logic [CW-1:0] pclk;
    logic [FW-1:0] pfrm;
    logic pstb;
    logic [NE-1:0] evt;

    int n_chk = 0, n_bad = 0;
    bit chk_en = 0, done = 0;

    always #2.5 clk = ~clk;

    radio_frame_timer #(.CLK_W(CW), .SYM_W(SW), .FRM_W(FW), .DEPTH(DEP),
                        .NEVT(NE), .EVT_W(EW)) u0 (
        .clk(clk), .rst(rst), .sync_i(sync), .lut_tc_i(lut),
        .sym_tc_i(sym_tc), .frm_tc_i(frm_tc), .ul_init_i(ul_init),
        .dl_init_i(dl_init), .phy_tc_i(phy_tc), .evt_sel_i(esel),
        .evt_mod_i(emod), .evt_off_i(eoff), .tmr_clk_o(tclk),
        .tmr_sym_o(tsym), .tmr_frm_o(tfrm), .sym_stb_o(sstb),
        .frm_stb_o(fstb), .phy_clk_o(pclk), .phy_frm_o(pfrm),
        .phy_stb_o(pstb), .evt_o(evt));

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model built from the requirements ----------
    int m_clk [3], m_sym [3], m_frm [3], m_idx [3];
    int p_clk, p_frm;
    bit e_act [NE];
    int e_cnt [NE];

    function automatic int lut_at(int i);
        return int'(lut[i*CW +: CW]);
    endfunction
    function automatic bit m_sstb(int t);
        return m_clk[t] == lut_at(m_idx[t]);
    endfunction
    function automatic bit m_fstb(int t);
        return m_sstb(t) && (m_sym[t] == int'(sym_tc));
    endfunction
    function automatic bit m_evt(int e);
        return e_act[e] && (e_cnt[e] == 0);
    endfunction

    always @(posedge clk) begin
        bit r [6];
        int md, sl;
        for (int t = 0; t < 3; t++) begin
            r[2*t]   = m_sstb(t);
            r[2*t+1] = m_fstb(t);
        end
        if (rst) begin
            for (int t = 0; t < 3; t++) begin
                m_clk[t] = 0; m_sym[t] = 0; m_frm[t] = 0; m_idx[t] = 0;
            end
            for (int e = 0; e < NE; e++) begin e_act[e] = 0; e_cnt[e] = 0; end
            p_clk = 0; p_frm = 0;
        end else begin
            for (int e = 0; e < NE; e++) begin
                md = int'(emod[e*EW +: EW]);
                sl = int'(esel[e*3 +: 3]);
                if (sync) begin e_act[e] = 0; e_cnt[e] = 0; end
                else if (md == 0) e_act[e] = 0;
                else if (sl < 6 && r[sl]) begin
                    e_act[e] = 1; e_cnt[e] = int'(eoff[e*EW +: EW]);
                end else if (e_act[e])
                    e_cnt[e] = (e_cnt[e] == 0) ? md - 1 : e_cnt[e] - 1;
            end
            for (int t = 0; t < 3; t++) begin
                if (sync) begin
                    m_clk[t] = (t == 0) ? 0 : (t == 1) ? int'(ul_init) : int'(dl_init);
                    m_sym[t] = 0; m_frm[t] = 0; m_idx[t] = 0;
                end else if (!r[2*t]) m_clk[t]++;
                else begin
                    m_clk[t] = 0;
                    if (r[2*t+1]) begin
                        m_sym[t] = 0; m_idx[t] = 0;
                        m_frm[t] = (m_frm[t] == int'(frm_tc)) ? 0 : m_frm[t] + 1;
                    end else begin
                        m_sym[t]++;
                        m_idx[t] = (m_idx[t] == DEP - 1) ? 0 : m_idx[t] + 1;
                    end
                end
            end
            if (sync) begin p_clk = 0; p_frm = 0; end
            else if (p_clk == int'(phy_tc)) begin
                p_clk = 0; p_frm = (p_frm + 1) % (1 << FW);
            end else p_clk++;
        end
    end

    // per-cycle comparison, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (chk_en && !rst) begin
            for (int t = 0; t < 3; t++) begin
                chk(int'(tclk[t*CW +: CW]) == m_clk[t] && sstb[t] == m_sstb(t),
                    (t == 0) ? "R2 main clock/strobe" : "R5 offset clock/strobe",
                    int'(tclk[t*CW +: CW]), m_clk[t]);
                chk(int'(tsym[t*SW +: SW]) == m_sym[t] && int'(tfrm[t*FW +: FW]) == m_frm[t]
                    && fstb[t] == m_fstb(t), "R4 symbol/frame",
                    int'(tsym[t*SW +: SW]), m_sym[t]);
            end
            chk(int'(pclk) == p_clk && int'(pfrm) == p_frm && pstb == (p_clk == int'(phy_tc)),
                "R6 phy timer", int'(pclk), p_clk);
            for (int e = 0; e < NE; e++)
                chk(evt[e] == m_evt(e), "R7 event strobe", int'(evt[e]), int'(m_evt(e)));
        end
    end

    task automatic set_row(row_t rw);
        for (int i = 0; i < DEP; i++) lut[i*CW +: CW] = CW'(rw.lutb + i % 3);
        sym_tc = SW'(rw.stc); frm_tc = FW'(rw.ftc);
        ul_init = CW'(rw.ul); dl_init = CW'(rw.dl); phy_tc = CW'(rw.ptc);
        for (int k = 0; k < NE; k++) begin
            esel[k*3 +: 3]  = 3'((k + rw.rot) % 8);
            emod[k*EW +: EW] = EW'(rw.modb + k);
            eoff[k*EW +: EW] = EW'(rw.offb * k);
        end
    endtask

    task automatic do_sync();
        @(negedge clk) sync = 1'b1;
        @(negedge clk) sync = 1'b0;
    endtask

    initial begin
        int n1, n2, cnt;
        bit s;
        set_row(ROWS[0]);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state visible before the first running edge
        chk(tclk == '0 && tsym == '0 && tfrm == '0, "R1 radio counts zero", int'(tclk[CW-1:0]), 0);
        chk(pclk == '0 && pfrm == '0, "R1 phy counts zero", int'(pclk), 0);
        chk(evt == '0, "R1 events quiet", int'(evt), 0);
        chk_en = 1;

        // table walk: each row reconfigures, syncs and runs under the model
        for (int v = 0; v < 4; v++) begin
            set_row(ROWS[v]);
            do_sync();
            repeat (300) @(negedge clk);
        end

        // R3: per-symbol lengths follow the table, index wraps 15 -> 0
        for (int i = 0; i < DEP; i++) lut[i*CW +: CW] = CW'(i + 2);
        sym_tc = 8'd20; frm_tc = 12'd5;
        do_sync();
        for (int k = 0; k < 18; k++) begin
            cnt = 0;
            do begin
                cnt++; s = sstb[0];
                @(negedge clk);
            end while (!s);
            chk(cnt == (k % 16) + 3, "R3 symbol length", cnt, (k % 16) + 3);
        end

        // R5, R7, R8: long frames, event 0 on main frame, others off
        for (int i = 0; i < DEP; i++) lut[i*CW +: CW] = CW'(40);
        sym_tc = 8'd3; frm_tc = 12'd100; ul_init = 22'd5; dl_init = 22'd9;
        emod = '0; eoff = '0; esel = '0;
        esel[2:0] = 3'd1; emod[EW-1:0] = 22'd7; eoff[EW-1:0] = 22'd2;
        do_sync();
        chk(int'(tclk[CW +: CW]) == 5, "R5 uplink init", int'(tclk[CW +: CW]), 5);
        chk(int'(tclk[2*CW +: CW]) == 9, "R5 downlink init", int'(tclk[2*CW +: CW]), 9);
        chk(int'(tclk[CW-1:0]) == 0, "R5 main init", int'(tclk[CW-1:0]), 0);
        n1 = -1; n2 = -1;
        for (int n = 0; n < 400 && n2 < 0; n++) begin
            if (evt[0]) begin
                if (n1 < 0) n1 = n; else n2 = n;
            end
            @(negedge clk);
        end
        chk(n1 == 166, "R7 first event after offset", n1, 166);
        chk(n2 - n1 == 7, "R8 event period", n2 - n1, 7);

        // R8 modulo 1 fires every cycle; R10 sync silences it
        emod[EW-1:0] = 22'd1; eoff[EW-1:0] = 22'd0;
        do_sync();
        repeat (170) @(negedge clk);
        chk(evt[0] == 1'b1, "R8 modulo one continuous", int'(evt[0]), 1);
        do_sync();
        cnt = 0;
        for (int n = 0; n < 60; n++) begin
            cnt += int'(evt[0]);
            @(negedge clk);
        end
        chk(cnt == 0, "R10 quiet after sync", cnt, 0);

        // R9: modulo 0 disables an event that was firing
        repeat (120) @(negedge clk);
        chk(evt[0] == 1'b1, "R9 precondition firing", int'(evt[0]), 1);
        emod[EW-1:0] = '0;
        @(negedge clk);
        cnt = 0;
        for (int n = 0; n < 200; n++) begin
            cnt += int'(evt[0]);
            @(negedge clk);
        end
        chk(cnt == 0, "R9 modulo zero silent", cnt, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule